// File: doc/BRIEF.md
# CPU/PCI Clock Divider with Stop Gating

This block takes one CPU-rate clock and derives a family of gated clocks from it. It produces a set of CPU-rate outputs and a bank of bus-rate outputs. The bus rate is the CPU rate divided by two or by three, chosen by a speed-select pin. One bus-rate output always runs. The others obey an active-low bus-stop input. The CPU-rate outputs obey an active-low CPU-stop input. An active-low sleep input parks every output low. Stopping and restarting always happen on whole pulses, so no output ever shows a shortened high time.

All three control inputs pass through a two-flop synchronizer before use. Gate enables are captured on the falling clock edge, and only while the clock they mask is low. Divide-by-three reaches a 50% duty cycle by OR-ing a rising-edge phase flag with a copy of it delayed by half a cycle. A power state machine has three states. RUN is normal operation. DRAIN waits for the end of the current bus cycle. DOWN holds the divider parked and latches the speed select. Its transitions are: RUN→DRAIN when sleep is seen low; DRAIN→RUN when sleep returns high; DRAIN→DOWN at the end of a bus cycle once the free gate has closed; DOWN→RUN when sleep is seen high. Reset enters DOWN, so leaving reset follows the same wake path as leaving sleep.

Top module: `cpupci_clkgen`

## Requirements
- R1: While reset is asserted every output is low. After reset is released with all control inputs high, all outputs toggle without further action.
- R2: With speed select 0 latched, the bus clocks have a period of 2 CPU cycles and are high for exactly 1 CPU cycle.
- R3: With speed select 1 latched, the bus clocks have a period of 3 CPU cycles and are high for exactly 1.5 CPU cycles.
- R4: CPU-stop low halts the CPU outputs low. After the input changes, exactly 2 further CPU pulses appear. When CPU-stop returns high, the first full pulse starts on the third CPU rising edge.
- R5: The bus-stop input is sampled at each rising edge of the free bus clock and acts from the next bus cycle. While it is low the gated bus outputs stay 0, and while it is high they run. After a falling bus-stop, 1 or 2 further gated pulses appear.
- R6: The free-running bus output is never stopped by the bus-stop input.
- R7: Sleep low parks every output low after whole pulses. Sleep high restarts them with full pulses, and the divider phase re-initializes on wake.
- R8: Every high pulse on any output has full width: half a CPU cycle on CPU outputs, and the R2/R3 width on bus outputs.
- R9: All CPU outputs are identical. Every gated bus output rises in the same CPU cycle as the free bus output and is never high while the free output is low.
- R10: Speed select is taken only in reset or DOWN. A change while running leaves the bus period unchanged until the next sleep cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-rate source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spd_sel_i | input | 1 | 0: bus = CPU/2, 1: bus = CPU/3 |
| cpu_halt_ni | input | 1 | Active-low CPU-output stop |
| pci_halt_ni | input | 1 | Active-low gated bus-output stop |
| sleep_ni | input | 1 | Active-low park of all outputs |
| cpu_clk_o | output | NCPU | Gated CPU-rate clocks |
| pci_free_o | output | 1 | Bus-rate clock exempt from bus-stop |
| pci_clk_o | output | NPCI | Bus-rate clocks gated by bus-stop |

## Verification
The bus-stop sampling and the sleep drain both update their gates on the same falling edge, inside the last phase of a bus cycle, so they can collide. The bench drives bus-stop and sleep low in the same cycle. It then checks that every output parks low on whole pulses. After wake, with bus-stop still low, the free clock must resume while the gated clocks stay silent; they resume only once bus-stop is released. A half-cycle pulse-width monitor runs throughout and flags any runt or misaligned rise that such a collision could produce.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
    typedef enum logic [1:0] {
        PW_RUN   = 2'd0,
        PW_DRAIN = 2'd1,
        PW_DOWN  = 2'd2
    } pw_state_e;

    localparam int unsigned PH_W = 2;

    // index of the final phase of one bus cycle for a given divide ratio
    function automatic logic [PH_W-1:0] last_phase(input logic div3);
        return div3 ? PH_W'(2) : PH_W'(1);
    endfunction
endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= {W{RST_VAL}};
            q_o    <= {W{RST_VAL}};
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/ckg_pwr_fsm.sv
module ckg_pwr_fsm
    import ckg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic awake_i,
    input  logic wrap_i,
    input  logic free_gate_i,
    output logic run_o,
    output logic hold_o
);
    pw_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PW_RUN:   if (!awake_i) st_d = PW_DRAIN;
            PW_DRAIN: begin
                if (awake_i)                       st_d = PW_RUN;
                else if (wrap_i && !free_gate_i)   st_d = PW_DOWN;
            end
            PW_DOWN:  if (awake_i) st_d = PW_RUN;
            default:  st_d = PW_DOWN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= PW_DOWN;
        else         st_q <= st_d;
    end

    always_comb begin
        run_o  = (st_q == PW_RUN);
        hold_o = (st_q == PW_DOWN);
    end

    // R7
    drain_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == PW_RUN && !awake_i) |=> (st_q == PW_DRAIN));

    // R7
    wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == PW_DOWN && awake_i) |=> (st_q == PW_RUN));
endmodule

// File: rtl/ckg_phase_div.sv
module ckg_phase_div
    import ckg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic sel_i,
    output logic wrap_o,
    output logic base_o
);
    logic [PH_W-1:0] ph_q;
    logic            div3_q;
    logic            hi_p_q;
    logic            hi_n_q;

    assign wrap_o = (ph_q == last_phase(div3_q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q   <= last_phase(1'b0);
            div3_q <= 1'b0;
            hi_p_q <= 1'b0;
        end else if (hold_i) begin
            div3_q <= sel_i;
            ph_q   <= last_phase(sel_i);
            hi_p_q <= 1'b0;
        end else begin
            ph_q   <= wrap_o ? '0 : ph_q + 1'b1;
            hi_p_q <= wrap_o;
        end
    end

    // half-cycle delayed copy widens the divide-by-3 high time to 1.5 cycles
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hi_n_q <= 1'b0;
        else         hi_n_q <= hi_p_q;
    end

    assign base_o = hi_p_q | (div3_q & hi_n_q);

    // R3
    phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ph_q <= last_phase(div3_q));

    // R9
    phase_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hi_p_q) |-> (ph_q == '0));
endmodule

// File: rtl/cpupci_clkgen.sv
module cpupci_clkgen #(
    parameter int NCPU = 2,
    parameter int NPCI = 5
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            spd_sel_i,
    input  logic            cpu_halt_ni,
    input  logic            pci_halt_ni,
    input  logic            sleep_ni,
    output logic [NCPU-1:0] cpu_clk_o,
    output logic            pci_free_o,
    output logic [NPCI-1:0] pci_clk_o
);
    localparam int NCTL = 3;

    logic [NCTL-1:0] ctl_raw, ctl_s;
    logic awake, pci_en_s, cpu_en_s;
    logic run, hold, wrap, base;
    logic pci_samp_q;
    logic cpu_gate_q, free_gate_q, pci_gate_q;

    assign ctl_raw = {sleep_ni, pci_halt_ni, cpu_halt_ni};

    ckg_sync #(.W(NCTL), .RST_VAL(1'b1)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (ctl_raw),
        .q_o   (ctl_s)
    );

    assign awake    = ctl_s[2];
    assign pci_en_s = ctl_s[1];
    assign cpu_en_s = ctl_s[0];

    ckg_pwr_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .awake_i    (awake),
        .wrap_i     (wrap),
        .free_gate_i(free_gate_q),
        .run_o      (run),
        .hold_o     (hold)
    );

    ckg_phase_div u_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .hold_i(hold),
        .sel_i (spd_sel_i),
        .wrap_o(wrap),
        .base_o(base)
    );

    // bus-stop captured on each free rising edge; tracked while parked
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           pci_samp_q <= 1'b1;
        else if (hold || wrap) pci_samp_q <= pci_en_s;
    end

    // enables move only on the falling edge, inside the low part of each clock
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cpu_gate_q  <= 1'b0;
            free_gate_q <= 1'b0;
            pci_gate_q  <= 1'b0;
        end else begin
            cpu_gate_q <= cpu_en_s & awake;
            if (wrap) begin
                free_gate_q <= run;
                pci_gate_q  <= run & pci_samp_q;
            end
        end
    end

    generate
        for (genvar gc = 0; gc < NCPU; gc++) begin : g_cpu
            assign cpu_clk_o[gc] = clk_i & cpu_gate_q;
        end
        for (genvar gp = 0; gp < NPCI; gp++) begin : g_pci
            assign pci_clk_o[gp] = base & pci_gate_q;
        end
    endgenerate

    assign pci_free_o = base & free_gate_q;

    // R5
    pci_gate_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pci_gate_q) |-> wrap);

    // R8
    free_gate_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(free_gate_q) |-> wrap);

    // R6
    free_stop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(free_gate_q) |-> !run);

    // R7
    down_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold |-> !free_gate_q);
endmodule

// File: tb/cpupci_clkgen_tb.sv
module cpupci_clkgen_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, sel, cs, ps, pd;
    logic [1:0] cpu;
    logic       free;
    logic [4:0] gat;

    cpupci_clkgen #(.NCPU(2), .NPCI(5)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .spd_sel_i  (sel),
        .cpu_halt_ni(cs),
        .pci_halt_ni(ps),
        .sleep_ni   (pd),
        .cpu_clk_o  (cpu),
        .pci_free_o (free),
        .pci_clk_o  (gat)
    );

    typedef struct packed {
        logic       sel;
        logic       cs;
        logic       ps;
        logic       pd;
        logic [4:0] ecpu;
        logic [4:0] efree;
        logic [4:0] egat;
    } vec_t;

    // expected rising-edge counts over a 12-cycle window
    localparam vec_t VEC [10] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 5'd12, 5'd6, 5'd6},
        '{1'b0, 1'b0, 1'b1, 1'b1, 5'd0,  5'd6, 5'd6},
        '{1'b0, 1'b1, 1'b0, 1'b1, 5'd12, 5'd6, 5'd0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd6, 5'd0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 5'd0,  5'd0, 5'd0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 5'd12, 5'd4, 5'd4},
        '{1'b1, 1'b1, 1'b0, 1'b1, 5'd12, 5'd4, 5'd0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 5'd0,  5'd4, 5'd4},
        '{1'b1, 1'b1, 1'b1, 1'b0, 5'd0,  5'd0, 5'd0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 5'd0,  5'd4, 5'd0}
    };

    int n_chk = 0, n_fail = 0;
    int c_cpu, c_free, c_gat;
    int run_cpu, run_free, run_gat;
    logic p_cpu, p_free, p_gat;
    logic cur_sel;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic clr();
        c_cpu = 0; c_free = 0; c_gat = 0;
    endtask

    // half-cycle sampler: counts rises and measures every high pulse
    task automatic half_sample();
        int w;
        if (!rst_n) begin
            p_cpu = 0; p_free = 0; p_gat = 0;
            run_cpu = 0; run_free = 0; run_gat = 0;
            return;
        end
        w = cur_sel ? 3 : 2;
        // R9 outputs consistent, gated rise only with free rise
        chk((cpu[0] == cpu[1]) && (gat == 5'h00 || gat == 5'h1f) &&
            (!gat[0] || free) && !(gat[0] && !p_gat && p_free),
            "R9", {cpu, free, gat}, 0);
        if (cpu[0] && !p_cpu)  c_cpu++;
        if (free && !p_free)   c_free++;
        if (gat[0] && !p_gat)  c_gat++;
        if (cpu[0]) run_cpu++;
        else if (run_cpu != 0) begin chk(run_cpu == 1, "R8 cpu width", run_cpu, 1); run_cpu = 0; end
        if (free) run_free++;
        else if (run_free != 0) begin chk(run_free == w, "R8 free width", run_free, w); run_free = 0; end
        if (gat[0]) run_gat++;
        else if (run_gat != 0) begin chk(run_gat == w, "R8 gated width", run_gat, w); run_gat = 0; end
        p_cpu = cpu[0]; p_free = free; p_gat = gat[0];
    endtask

    always @(posedge clk) begin #2; if (!done) half_sample(); end
    always @(negedge clk) begin #2; if (!done) half_sample(); end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int first;
        rst_n = 0; sel = 0; cs = 1; ps = 1; pd = 1; cur_sel = 0;
        clr();
        // R1 reset state, sampled with clk high
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #2;
            chk(cpu == 2'b00 && !free && gat == 5'h00, "R1 reset low", {cpu, free, gat}, 0);
        end
        wait_cyc(1);
        rst_n = 1;
        clr();
        wait_cyc(8);
        chk(c_cpu >= 5, "R1 cpu runs", c_cpu, 5);
        chk(c_free >= 3, "R1 free runs", c_free, 3);

        // vector table
        for (int i = 0; i < 10; i++) begin
            if (VEC[i].sel != cur_sel) begin
                pd = 0;
                wait_cyc(10);
                sel = VEC[i].sel; cur_sel = VEC[i].sel;
                wait_cyc(2);
            end
            cs = VEC[i].cs; ps = VEC[i].ps; pd = VEC[i].pd;
            wait_cyc(10);
            clr();
            wait_cyc(12);
            chk(c_cpu == int'(VEC[i].ecpu), $sformatf("R4 vec%0d cpu", i), c_cpu, int'(VEC[i].ecpu));
            chk(c_free == int'(VEC[i].efree), $sformatf("R6 vec%0d free", i), c_free, int'(VEC[i].efree));
            chk(c_gat == int'(VEC[i].egat), $sformatf("R5 vec%0d gated", i), c_gat, int'(VEC[i].egat));
        end

        // R4 stop and restart latency (select 1 latched)
        cs = 1; ps = 1; pd = 1;
        wait_cyc(10);
        cs = 0; clr();
        wait_cyc(8);
        chk(c_cpu == 2, "R4 pulses after stop", c_cpu, 2);
        cs = 1;
        first = 0;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #2;
            if (first == 0 && cpu[0]) first = k;
        end
        chk(first == 3, "R4 restart edge", first, 3);

        // R5 / R6 bus-stop under divide-by-3
        wait_cyc(6);
        ps = 0; clr();
        wait_cyc(12);
        chk(c_gat >= 1 && c_gat <= 2, "R5 pulses after stop", c_gat, 2);
        chk(c_free == 4, "R6 free keeps running", c_free, 4);
        clr();
        wait_cyc(6);
        chk(c_gat == 0, "R5 held low", c_gat, 0);
        chk(c_free == 2, "R6 free unaffected", c_free, 2);
        ps = 1;
        wait_cyc(8);

        // R10 select change while running is ignored
        sel = 0;
        wait_cyc(4);
        clr();
        wait_cyc(12);
        chk(c_free == 4, "R10 period kept", c_free, 4);
        pd = 0;
        wait_cyc(10);
        cur_sel = 0;
        pd = 1;
        wait_cyc(10);
        clr();
        wait_cyc(12);
        chk(c_free == 6, "R2 new period after sleep", c_free, 6);
        chk(c_gat == 6, "R2 gated period", c_gat, 6);

        // same cycle: bus-stop and sleep together
        ps = 0; pd = 0;
        wait_cyc(8);
        clr();
        wait_cyc(6);
        chk(c_cpu == 0 && c_free == 0 && c_gat == 0, "R7 all parked", c_cpu + c_free + c_gat, 0);
        pd = 1;
        wait_cyc(10);
        clr();
        wait_cyc(12);
        chk(c_free == 6, "R7 free resumes", c_free, 6);
        chk(c_cpu == 12, "R7 cpu resumes", c_cpu, 12);
        chk(c_gat == 0, "R5 gated stays stopped", c_gat, 0);
        ps = 1;
        wait_cyc(10);
        clr();
        wait_cyc(12);
        chk(c_gat == 6, "R5 gated resumes", c_gat, 6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule